// File: doc/BRIEF.md
# March Test Pattern Sequencer

This block generates the command, address and data stream for a march-style test of a dynamic memory array. After a start request it makes three passes over every cell. The first pass writes zeros. The second reads each cell expecting zero and then writes all-ones. The third reads expecting all-ones and then writes zero. Every cell operation becomes a short command sequence: a row open, a fill cycle, the column command or commands, a row close and a trailing fill cycle.

The cell order comes from a linear index. The index starts at zero in each pass and moves forward by a programmable odd stride, modulo the array size. A mode input decides whether the low index bits feed the column address or the row address, so either address can be the inner loop. Two optional insertions change the timing of the stream without changing its data:
- an idle pause between passes, for retention and disturb testing;
- single-row refresh commands, issued whenever a programmable cycle budget runs out.

Each read also produces the data the memory should return and a strobe for it. The strobe is delayed by the programmed read latency, so a downstream comparator can line the expected word up with the memory's answer.

Top module: `march_seq`

## Requirements
- R1: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5. A cell in pass 0 takes five cycles: ACT, NOP, WR, PRE, NOP. A cell in passes 1 and 2 takes six cycles: ACT, NOP, RD, WR, PRE, NOP.
- R2: Pass 0 writes all-zeros. Pass 1 expects all-zeros and writes all-ones. Pass 2 expects all-ones and writes all-zeros. `wdata` is zero in every cycle that is not WR.
- R3: In each pass, cell k uses index (k*step) mod 2^(ROW_W+COL_W). With `fast_row`=0, col = index[COL_W-1:0] and row = the upper bits. With `fast_row`=1, row = index[ROW_W-1:0] and col = the upper bits. Row and column hold for all cycles of the cell. `bank` carries the `bank_sel` value latched at start while busy.
- R4: With an odd step, each pass visits every (row, col) pair exactly once, and a pass has exactly 2^(ROW_W+COL_W) cells.
- R5: A start request with an even step sets `step_err` and starts no test. A start request with an odd step clears `step_err`.
- R6: When `pause_en` is set and `pause_len` is nonzero, exactly `pause_len` NOP cycles sit between pass 0 and pass 1, and again between pass 1 and pass 2. With a zero length, no pause is inserted.
- R7: A cycle counter starts at zero in the first cycle of a test and restarts at zero in the cycle after each REF. Whenever a cell or a pause ends while the counter is at least `ref_period` (and `ref_period` is nonzero), one REF cycle is issued before the next ACT. That REF cycle drives row = refresh row and col = 0. The refresh row starts at 0 and increases by one per REF.
- R8: A RD issued in cycle t raises `exp_valid` in cycle t+`cas_lat`, with `exp_data` equal to that read's expected word. Values of `cas_lat` are limited to the range 1..CL_MAX.
- R9: `done` is high for one cycle, in the cycle after the last PRE of pass 2. `busy` falls in the next cycle.
- R10: While idle, the outputs are: cmd NOP, row, col and bank zero, `busy` low. A start request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken only while idle |
| step | input | ROW_W+COL_W | Index stride, must be odd |
| fast_row | input | 1 | 1: row is the inner loop; 0: column is the inner loop |
| pause_en | input | 1 | Enables the pause between passes |
| pause_len | input | DIS_W | Pause length in cycles |
| ref_period | input | REF_W | Refresh cycle budget, 0 disables refresh |
| cas_lat | input | CL_W | Read latency for the expected-data strobe |
| bank_sel | input | BANK_W | Bank used for the whole test |
| cmd | output | 3 | Command code |
| bank | output | BANK_W | Bank address |
| row | output | ROW_W | Row address |
| col | output | COL_W | Column address |
| wdata | output | DATA_W | Write data |
| exp_data | output | DATA_W | Expected read data |
| exp_valid | output | 1 | Expected-data strobe |
| busy | output | 1 | Test in progress |
| done | output | 1 | End-of-test pulse |
| step_err | output | 1 | Last start request had an even step |

## Verification
The hardest case to reach from the ports is a refresh that falls at a pass boundary or right after a pause. Here the budget check must happen on the last cycle of the previous cell or pause, not at an arbitrary cycle. The bench reaches this case by running complete tests with a short refresh budget, so refreshes land at many different cell positions. A cycle-accurate model in the bench predicts every single REF from its own cycle counter. A start pulse injected in the middle of one such run shows that the stream continues unchanged.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } mcmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CELL,
        PH_PAUSE,
        PH_REF
    } phase_e;

    localparam logic [1:0] LAST_SWEEP = 2'd2;

    // Index of the final slot of one cell operation in a given sweep.
    function automatic logic [2:0] last_slot(input logic [1:0] sweep);
        return (sweep == 2'd0) ? 3'd4 : 3'd5;
    endfunction

    // Command issued in a given slot of a cell operation.
    function automatic mcmd_e slot_cmd(input logic [1:0] sweep, input logic [2:0] slot);
        if (sweep == 2'd0) begin
            case (slot)
                3'd0:    return CMD_ACT;
                3'd2:    return CMD_WR;
                3'd3:    return CMD_PRE;
                default: return CMD_NOP;
            endcase
        end else begin
            case (slot)
                3'd0:    return CMD_ACT;
                3'd2:    return CMD_RD;
                3'd3:    return CMD_WR;
                3'd4:    return CMD_PRE;
                default: return CMD_NOP;
            endcase
        end
    endfunction

    function automatic logic writes_ones(input logic [1:0] sweep);
        return sweep == 2'd1;
    endfunction

    function automatic logic expects_ones(input logic [1:0] sweep);
        return sweep == 2'd2;
    endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
    parameter int ROW_W    = 4,
    parameter int COL_W    = 3,
    parameter bit SCRAMBLE = 1'b0,
    localparam int ADDR_W  = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    input  logic [ADDR_W-1:0] step,
    input  logic              fast_row,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);

    logic [ADDR_W-1:0] idx;
    logic [ROW_W-1:0]  row_lin;

    // Linear index wraps naturally modulo 2^ADDR_W.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + step;
        end
    end

    always_comb begin
        if (fast_row) begin
            row_lin = idx[ROW_W-1:0];
            col     = idx[ADDR_W-1:ROW_W];
        end else begin
            col     = idx[COL_W-1:0];
            row_lin = idx[ADDR_W-1:COL_W];
        end
    end

    generate
        if (SCRAMBLE) begin : g_scramble
            assign row = row_lin ^ (row_lin >> 1);
        end else begin : g_plain
            assign row = row_lin;
        end
    endgenerate

endmodule

// File: rtl/march_lat_pipe.sv
module march_lat_pipe #(
    parameter int DATA_W = 8,
    parameter int CL_MAX = 4,
    localparam int CL_W  = $clog2(CL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [CL_W-1:0]   cas_lat,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    logic              vld [CL_MAX];
    logic [DATA_W-1:0] dat [CL_MAX];
    int unsigned       sel;

    generate
        for (genvar g = 0; g < CL_MAX; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) vld[0] <= 1'b0;
                    else     vld[0] <= push;
                    dat[0] <= push_data;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) vld[g] <= 1'b0;
                    else     vld[g] <= vld[g-1];
                    dat[g] <= dat[g-1];
                end
            end
        end
    endgenerate

    // Latency clamped into 1..CL_MAX.
    always_comb begin
        if (cas_lat == '0)                    sel = 0;
        else if (int'(cas_lat) > CL_MAX)      sel = CL_MAX - 1;
        else                                  sel = int'(cas_lat) - 1;
        valid = 1'b0;
        data  = '0;
        for (int i = 0; i < CL_MAX; i++) begin
            if (sel == i) begin
                valid = vld[i];
                data  = dat[i];
            end
        end
    end

endmodule

// File: rtl/march_ctrl.sv
module march_ctrl
    import march_pkg::*;
#(
    parameter int ROW_W   = 4,
    parameter int COL_W   = 3,
    parameter int BANK_W  = 2,
    parameter int DIS_W   = 16,
    parameter int REF_W   = 16,
    parameter int CL_W    = 3,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] step_in,
    input  logic              fast_row_in,
    input  logic              pause_en_in,
    input  logic [DIS_W-1:0]  pause_len_in,
    input  logic [REF_W-1:0]  ref_period_in,
    input  logic [CL_W-1:0]   cas_in,
    input  logic [BANK_W-1:0] bank_in,
    output phase_e            phase_o,
    output logic [1:0]        sweep_o,
    output logic [2:0]        slot_o,
    output logic              addr_clear,
    output logic              addr_advance,
    output logic [ADDR_W-1:0] step_o,
    output logic              fast_row_o,
    output logic [CL_W-1:0]   cas_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  ref_row_o,
    output logic              done_o,
    output logic              step_err_o
);

    phase_e            phase;
    logic [1:0]        sweep;
    logic [2:0]        slot;
    logic [ADDR_W-1:0] cell_cnt;
    logic [DIS_W-1:0]  pause_cnt;
    logic [REF_W-1:0]  ref_cnt;
    logic [ROW_W-1:0]  ref_row;
    logic              step_err;

    logic [ADDR_W-1:0] step_q;
    logic              fast_row_q;
    logic              pause_en_q;
    logic [DIS_W-1:0]  pause_len_q;
    logic [REF_W-1:0]  ref_per_q;
    logic [CL_W-1:0]   cas_q;
    logic [BANK_W-1:0] bank_q;

    logic   cell_end, last_cell, ref_due, pause_on;
    phase_e after_bnd;

    always_comb begin
        cell_end     = (phase == PH_CELL) && (slot == last_slot(sweep));
        last_cell    = &cell_cnt;
        ref_due      = (ref_per_q != '0) && (ref_cnt >= ref_per_q);
        pause_on     = pause_en_q && (pause_len_q != '0);
        after_bnd    = ref_due ? PH_REF : PH_CELL;
        done_o       = cell_end && last_cell && (sweep == LAST_SWEEP);
        addr_clear   = (phase == PH_IDLE) || (cell_end && last_cell);
        addr_advance = cell_end && !last_cell;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            sweep       <= '0;
            slot        <= '0;
            cell_cnt    <= '0;
            pause_cnt   <= '0;
            ref_cnt     <= '0;
            ref_row     <= '0;
            step_err    <= 1'b0;
            step_q      <= '0;
            fast_row_q  <= 1'b0;
            pause_en_q  <= 1'b0;
            pause_len_q <= '0;
            ref_per_q   <= '0;
            cas_q       <= '0;
            bank_q      <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (!step_in[0]) begin
                            step_err <= 1'b1;
                        end else begin
                            step_err    <= 1'b0;
                            step_q      <= step_in;
                            fast_row_q  <= fast_row_in;
                            pause_en_q  <= pause_en_in;
                            pause_len_q <= pause_len_in;
                            ref_per_q   <= ref_period_in;
                            cas_q       <= cas_in;
                            bank_q      <= bank_in;
                            phase       <= PH_CELL;
                            sweep       <= '0;
                            slot        <= '0;
                            cell_cnt    <= '0;
                            ref_cnt     <= '0;
                            ref_row     <= '0;
                        end
                    end
                end
                PH_CELL: begin
                    if (ref_cnt != '1) ref_cnt <= ref_cnt + 1'b1;
                    if (!cell_end) begin
                        slot <= slot + 3'd1;
                    end else begin
                        slot <= '0;
                        if (last_cell) begin
                            cell_cnt <= '0;
                            if (sweep == LAST_SWEEP) begin
                                phase <= PH_IDLE;
                            end else begin
                                sweep <= sweep + 2'd1;
                                if (pause_on) begin
                                    phase     <= PH_PAUSE;
                                    pause_cnt <= pause_len_q - 1'b1;
                                end else begin
                                    phase <= after_bnd;
                                end
                            end
                        end else begin
                            cell_cnt <= cell_cnt + 1'b1;
                            phase    <= after_bnd;
                        end
                    end
                end
                PH_PAUSE: begin
                    if (ref_cnt != '1) ref_cnt <= ref_cnt + 1'b1;
                    if (pause_cnt == '0) phase <= after_bnd;
                    else                 pause_cnt <= pause_cnt - 1'b1;
                end
                PH_REF: begin
                    ref_cnt <= '0;
                    ref_row <= ref_row + 1'b1;
                    phase   <= PH_CELL;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign phase_o    = phase;
    assign sweep_o    = sweep;
    assign slot_o     = slot;
    assign step_o     = step_q;
    assign fast_row_o = fast_row_q;
    assign cas_o      = cas_q;
    assign bank_o     = bank_q;
    assign ref_row_o  = ref_row;
    assign step_err_o = step_err;

endmodule

// File: rtl/march_seq.sv
module march_seq
    import march_pkg::*;
#(
    parameter int ROW_W    = 4,
    parameter int COL_W    = 3,
    parameter int BANK_W   = 2,
    parameter int DATA_W   = 8,
    parameter int CL_MAX   = 4,
    parameter int DIS_W    = 16,
    parameter int REF_W    = 16,
    parameter bit SCRAMBLE = 1'b0,
    localparam int ADDR_W  = ROW_W + COL_W,
    localparam int CL_W    = $clog2(CL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] step,
    input  logic              fast_row,
    input  logic              pause_en,
    input  logic [DIS_W-1:0]  pause_len,
    input  logic [REF_W-1:0]  ref_period,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] exp_data,
    output logic              exp_valid,
    output logic              busy,
    output logic              done,
    output logic              step_err
);

    phase_e            phase;
    logic [1:0]        sweep;
    logic [2:0]        slot;
    logic              addr_clear, addr_advance;
    logic [ADDR_W-1:0] step_q;
    logic              fast_row_q;
    logic [CL_W-1:0]   cas_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  ref_row;
    logic [ROW_W-1:0]  cell_row;
    logic [COL_W-1:0]  cell_col;
    mcmd_e             cmd_e;
    logic              rd_push;
    logic [DATA_W-1:0] rd_word;

    march_ctrl #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BANK_W(BANK_W),
        .DIS_W (DIS_W),
        .REF_W (REF_W),
        .CL_W  (CL_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .step_in      (step),
        .fast_row_in  (fast_row),
        .pause_en_in  (pause_en),
        .pause_len_in (pause_len),
        .ref_period_in(ref_period),
        .cas_in       (cas_lat),
        .bank_in      (bank_sel),
        .phase_o      (phase),
        .sweep_o      (sweep),
        .slot_o       (slot),
        .addr_clear   (addr_clear),
        .addr_advance (addr_advance),
        .step_o       (step_q),
        .fast_row_o   (fast_row_q),
        .cas_o        (cas_q),
        .bank_o       (bank_q),
        .ref_row_o    (ref_row),
        .done_o       (done),
        .step_err_o   (step_err)
    );

    march_addr_gen #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .SCRAMBLE(SCRAMBLE)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .clear   (addr_clear),
        .advance (addr_advance),
        .step    (step_q),
        .fast_row(fast_row_q),
        .row     (cell_row),
        .col     (cell_col)
    );

    always_comb begin
        busy  = (phase != PH_IDLE);
        cmd_e = CMD_NOP;
        row   = '0;
        col   = '0;
        case (phase)
            PH_CELL: begin
                cmd_e = slot_cmd(sweep, slot);
                row   = cell_row;
                col   = cell_col;
            end
            PH_REF: begin
                cmd_e = CMD_REF;
                row   = ref_row;
            end
            default: ;
        endcase
        bank    = busy ? bank_q : '0;
        wdata   = (cmd_e == CMD_WR && writes_ones(sweep)) ? '1 : '0;
        rd_push = (cmd_e == CMD_RD);
        rd_word = expects_ones(sweep) ? '1 : '0;
    end

    assign cmd = cmd_e;

    march_lat_pipe #(
        .DATA_W(DATA_W),
        .CL_MAX(CL_MAX)
    ) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .push     (rd_push),
        .push_data(rd_word),
        .cas_lat  (cas_q),
        .valid    (exp_valid),
        .data     (exp_data)
    );

endmodule

// File: rtl/march_seq_chk.sv
module march_seq_chk #(
    parameter int ROW_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cmd,
    input logic [ROW_W-1:0] row,
    input logic             busy,
    input logic             done,
    input logic             step_err
);
    import march_pkg::*;

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cmd == CMD_NOP);

    p_act_fill_r1: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_ACT |=> cmd == CMD_NOP);

    p_pre_fill_r1: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_PRE |=> cmd == CMD_NOP);

    p_rd_row_held_r3: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_RD |-> row == $past(row, 2));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_pre_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cmd) == CMD_PRE);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_err_no_run_r5: assert property (@(posedge clk) disable iff (rst)
        step_err |-> !busy);

    p_ref_then_act_r7: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_REF |=> cmd == CMD_ACT);

endmodule

bind march_seq march_seq_chk #(.ROW_W(ROW_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .row     (row),
    .busy    (busy),
    .done    (done),
    .step_err(step_err)
);

// File: tb/march_seq_bench.sv
module march_seq_bench;

    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int N      = 1 << ADDR_W;
    localparam int BANK_W = 2;
    localparam int DATA_W = 8;
    localparam int CL_MAX = 4;
    localparam int CL_W   = 3;
    localparam int DIS_W  = 16;
    localparam int REF_W  = 16;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, REF = 3'd5;
    localparam logic [DATA_W-1:0] ZERO = '0, ONES = '1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] step = 1;
    logic              fast_row = 1'b0;
    logic              pause_en = 1'b0;
    logic [DIS_W-1:0]  pause_len = '0;
    logic [REF_W-1:0]  ref_period = '0;
    logic [CL_W-1:0]   cas_lat = 3'd2;
    logic [BANK_W-1:0] bank_sel = '0;
    logic [2:0]        cmd;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] wdata, exp_data;
    logic              exp_valid, busy, done, step_err;

    int checks = 0;
    int fails  = 0;

    // bench model state
    int          cyc, since, last_since, poke, ref_row_m, ref_seen;
    bit          hv [8];
    logic [DATA_W-1:0] hd [8];

    always #5 clk = ~clk;

    march_seq u_march_seq (
        .clk(clk), .rst(rst), .start(start), .step(step), .fast_row(fast_row),
        .pause_en(pause_en), .pause_len(pause_len), .ref_period(ref_period),
        .cas_lat(cas_lat), .bank_sel(bank_sel), .cmd(cmd), .bank(bank),
        .row(row), .col(col), .wdata(wdata), .exp_data(exp_data),
        .exp_valid(exp_valid), .busy(busy), .done(done), .step_err(step_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    // Compare one cycle of outputs against the expectation, then advance a clock.
    task automatic obs(input logic [2:0] ecmd, input int erow, input int ecol,
                       input int ebank, input logic [DATA_W-1:0] ewd,
                       input logic [DATA_W-1:0] eexp, input bit edone, input bit ebusy);
        chk(cmd == ecmd, "R1", "cmd", cmd, ecmd);
        chk(row == erow, "R3", "row", row, erow);
        chk(col == ecol, "R3", "col", col, ecol);
        chk(bank == ebank, "R3", "bank", bank, ebank);
        chk(wdata == ewd, "R2", "wdata", wdata, ewd);
        chk(done == edone, "R9", "done", done, edone);
        chk(busy == ebusy, "R9", "busy", busy, ebusy);
        chk(exp_valid == hv[cas_lat-1], "R8", "exp_valid", exp_valid, hv[cas_lat-1]);
        if (hv[cas_lat-1])
            chk(exp_data == hd[cas_lat-1], "R8", "exp_data", exp_data, hd[cas_lat-1]);
        for (int i = 7; i > 0; i--) begin
            hv[i] = hv[i-1];
            hd[i] = hd[i-1];
        end
        hv[0] = (ecmd == RD);
        hd[0] = eexp;
        last_since = since;
        since = (ecmd == REF) ? 0 : since + 1;
        start = (cyc == poke);
        cyc++;
        @(posedge clk);
        #1 start = 1'b0;
        @(negedge clk);
    endtask

    // R7: refresh decision taken at the end of a cell or a pause
    task automatic boundary(input int rp, input int bk);
        if (rp != 0 && last_since >= rp) begin
            obs(REF, ref_row_m, 0, bk, ZERO, ZERO, 1'b0, 1'b1);
            ref_row_m = (ref_row_m + 1) % (1 << ROW_W);
            ref_seen++;
        end
    endtask

    task automatic run_test(input int st, input bit fr, input bit pe, input int pl,
                            input int cl, input int rp, input int bk, input int pk);
        int idx;
        int erow, ecol;
        int visited;
        bit vis [N];
        logic [DATA_W-1:0] wv, ev;
        step = ADDR_W'(st); fast_row = fr; pause_en = pe; pause_len = DIS_W'(pl);
        cas_lat = CL_W'(cl); ref_period = REF_W'(rp); bank_sel = BANK_W'(bk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        @(negedge clk);
        cyc = 0; since = 0; last_since = 0; poke = pk; ref_row_m = 0; ref_seen = 0;
        for (int i = 0; i < 8; i++) begin hv[i] = 1'b0; hd[i] = '0; end
        for (int s = 0; s < 3; s++) begin
            if (s > 0) begin
                if (pe && pl != 0) begin
                    for (int d = 0; d < pl; d++) obs(NOP, 0, 0, bk, ZERO, ZERO, 1'b0, 1'b1); // R6
                end
                boundary(rp, bk);
            end
            idx = 0;
            for (int i = 0; i < N; i++) vis[i] = 1'b0;
            wv = (s == 1) ? ONES : ZERO;
            ev = (s == 2) ? ONES : ZERO;
            for (int c = 0; c < N; c++) begin
                if (c > 0) boundary(rp, bk);
                if (fr) begin
                    erow = idx % (1 << ROW_W);
                    ecol = idx >> ROW_W;
                end else begin
                    ecol = idx % (1 << COL_W);
                    erow = idx >> COL_W;
                end
                if (row == erow && col == ecol) vis[erow * (1 << COL_W) + ecol] = 1'b1;
                obs(ACT, erow, ecol, bk, ZERO, ZERO, 1'b0, 1'b1);
                obs(NOP, erow, ecol, bk, ZERO, ZERO, 1'b0, 1'b1);
                if (s == 0) begin
                    obs(WR, erow, ecol, bk, wv, ZERO, 1'b0, 1'b1);
                end else begin
                    obs(RD, erow, ecol, bk, ZERO, ev, 1'b0, 1'b1);
                    obs(WR, erow, ecol, bk, wv, ZERO, 1'b0, 1'b1);
                end
                obs(PRE, erow, ecol, bk, ZERO, ZERO, 1'b0, 1'b1);
                obs(NOP, erow, ecol, bk, ZERO, ZERO, (s == 2 && c == N - 1), 1'b1);
                idx = (idx + st) % N;
            end
            visited = 0;
            for (int i = 0; i < N; i++) visited += vis[i];
            chk(visited == N, "R4", "cells visited in pass", visited, N);
        end
        // tail: idle outputs, pending strobes drain (R10, R8)
        for (int t = 0; t < 5; t++) obs(NOP, 0, 0, 0, ZERO, ZERO, 1'b0, 1'b0);
        chk(step_err == 1'b0, "R5", "step_err after odd start", step_err, 0);
        poke = -1;
    endtask

    task automatic t_reset;
        chk(cmd == NOP, "R10", "reset cmd", cmd, NOP);
        chk(busy == 1'b0, "R10", "reset busy", busy, 0);
        chk(done == 1'b0, "R9", "reset done", done, 0);
        chk(exp_valid == 1'b0, "R8", "reset exp_valid", exp_valid, 0);
        chk(step_err == 1'b0, "R5", "reset step_err", step_err, 0);
        chk(row == 0 && col == 0 && bank == 0, "R10", "reset address", {row, col, bank}, 0);
    endtask

    task automatic t_even_step;
        step = 7'd4;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        @(negedge clk);
        chk(step_err == 1'b1, "R5", "step_err after even step", step_err, 1);
        for (int i = 0; i < 4; i++) begin
            chk(busy == 1'b0, "R5", "busy after even step", busy, 0);
            chk(cmd == NOP, "R5", "cmd after even step", cmd, NOP);
            @(negedge clk);
        end
    endtask

    task automatic t_basic;      // R1 R2 R3 R8 R9, column inner loop, unit stride
        run_test(1, 1'b0, 1'b0, 0, 2, 0, 2, -1);
    endtask

    task automatic t_row_fast_pause;   // R3 R4 R6 R8, row inner loop, stride 3, pause
        run_test(3, 1'b1, 1'b1, 9, 4, 0, 1, -1);
    endtask

    task automatic t_refresh;    // R7 R10, stride 5, zero-length pause, start while busy
        run_test(5, 1'b0, 1'b1, 0, 1, 100, 3, 300);
        chk(ref_seen > 0, "R7", "refresh commands issued", ref_seen, 1);
    endtask

    task automatic t_refresh_pause;    // R6 R7, refresh falling after a pause
        run_test(127, 1'b1, 1'b1, 40, 3, 37, 0, -1);
        chk(ref_seen > 0, "R7", "refresh commands with pause", ref_seen, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc = 0; poke = -1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_even_step();
        t_basic();
        t_row_fast_pause();
        t_refresh();
        t_refresh_pause();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule